// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a small window of configuration registers through two adjacent byte addresses in I/O space. The lower address holds a pointer; the upper address is a data path to whichever register the pointer selects. A strap input, captured once after reset, picks which of two fixed 16-bit address pairs the window occupies.

Behind the data path sit a device-select register, two read-only identifiers and a bank of device registers. The bank holds the device enable, a 16-bit I/O base, an interrupt line number with a wake enable, and an interrupt type. It answers only while the device-select register holds the expected number. The stored bank settings drive dedicated outputs continuously, so the rest of the chip sees them no matter where the pointer is or what the device-select register holds. Bus cycle decoding is done elsewhere. This block sees a plain address with one-cycle read and write strobes. Write data lands on the clock edge. Read data and the hit flag are combinational.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset the pointer and the device-select register read 00h, and the device enable, I/O base, interrupt number and wake enable are all zero. The interrupt type register reads 03h, so `irq_type_o` is 2'b11.
- R2: The strap is captured on the first clock edge after reset is released. A captured 1 places the pair at 007Eh/007Fh and a captured 0 places it at 00EEh/00EFh. Later changes of the strap have no effect until the next reset.
- R3: The block decodes only an exact 16-bit match to the pair's two addresses. For any other address, `io_hit_o` is 0, read data is 00h and a write changes nothing.
- R4: A write to the pointer address loads the pointer, and a read of the pointer address returns it.
- R5: The data address reads and writes the register the pointer selects. The device-select register at index 07h is fully read/write.
- R6: Index 20h always reads FEh and index 27h always reads the revision parameter, default 01h. Writes to either are ignored.
- R7: Indices 30h to 71h respond only while the device-select register equals 1Ah. Otherwise they read 00h, writes are dropped, and stored bank values are kept.
- R8: Index 30h bit 0 is the device enable and drives `dev_active_o`. Bits 7..1 read 0.
- R9: Index 60h holds base bits 15..8 and index 61h holds base bits 7..0. Bits 3..0 of 61h read 0000 and ignore writes. `dev_base_o` shows the 16-bit result.
- R10: Index 70h bits 3..0 hold the interrupt number (`irq_num_o`) and bit 4 holds the wake enable (`irq_wake_o`). Bits 7..5 read 0.
- R11: Index 71h has bit 1 writable. Bit 0 always reads 1 and bits 7..2 read 0. `irq_type_o` equals bits 1..0.
- R12: A read of any index with no register behind it returns 00h, and a write to one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Address-pair select, captured after reset |
| io_addr_i | input | 16 | I/O address |
| io_rd_i | input | 1 | Read strobe |
| io_wr_i | input | 1 | Write strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, 00h when not hit |
| io_hit_o | output | 1 | Access targets the pair |
| dev_active_o | output | 1 | Device enable |
| dev_base_o | output | 16 | Device I/O base |
| irq_num_o | output | 4 | Interrupt line number |
| irq_wake_o | output | 1 | Wake on interrupt enable |
| irq_type_o | output | 2 | Interrupt type bits |

## Verification
The data port is exercised with all-ones and mixed patterns such as 55h, AAh and 12h/FFh. All-ones writes expose bits that ought to stay read-only, and mixed patterns reveal swapped or mis-sliced fields on both the read path and the outputs. The same bank writes are issued with device-select at 00h, 1Ah and 1Bh. This separates correct gating from an off-by-one compare and shows that stored values survive deselection. Near-miss addresses that differ only in the upper byte or by one show that the match covers the full 16 bits. Two resets with opposite straps, the second followed by a strap toggle, show that the strap is captured only once.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  localparam int unsigned CFG_DW = 8;
  localparam int unsigned CFG_AW = 16;

  typedef logic [CFG_DW-1:0] cfg_byte_t;

  localparam cfg_byte_t IDX_LDN      = 8'h07;
  localparam cfg_byte_t IDX_DEVID    = 8'h20;
  localparam cfg_byte_t IDX_REVID    = 8'h27;
  localparam cfg_byte_t IDX_ACT      = 8'h30;
  localparam cfg_byte_t IDX_BASE_HI  = 8'h60;
  localparam cfg_byte_t IDX_BASE_LO  = 8'h61;
  localparam cfg_byte_t IDX_IRQ_NUM  = 8'h70;
  localparam cfg_byte_t IDX_IRQ_TYPE = 8'h71;

  typedef struct packed {
    logic              active;
    logic [CFG_AW-1:0] base;
    logic [3:0]        irq_num;
    logic              irq_wake;
    logic [1:0]        irq_type;
  } dev_cfg_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int unsigned AW            = 16,
  parameter logic [AW-1:0] BASE_STRAP1 = 16'h007E,
  parameter logic [AW-1:0] BASE_STRAP0 = 16'h00EE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic          idx_wr_o,
  output logic          idx_rd_o,
  output logic          dat_wr_o,
  output logic          dat_rd_o,
  output logic          hit_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          strap_q, strap_done_q;
  logic [AW-1:0] pair_base;
  logic          idx_sel, dat_sel;

  // strap captured once, first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= 1'b1;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= strap_i;
      strap_done_q <= 1'b1;
    end
  end

  assign pair_base = strap_q ? BASE_STRAP1 : BASE_STRAP0;
  assign idx_sel   = (addr_i == pair_base);
  assign dat_sel   = (addr_i == pair_base + ONE);

  assign idx_wr_o = wr_i & idx_sel;
  assign idx_rd_o = rd_i & idx_sel;
  assign dat_wr_o = wr_i & dat_sel;
  assign dat_rd_o = rd_i & dat_sel;
  assign hit_o    = (rd_i | wr_i) & (idx_sel | dat_sel);

  // R2
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q |=> $stable(strap_q));

  // R3
  pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idx_sel, dat_sel}));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfgspace_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bank_en_i,
  input  cfg_byte_t idx_i,
  input  logic      wr_i,
  input  cfg_byte_t wdata_i,
  output cfg_byte_t rdata_o,
  output dev_cfg_t  cfg_o
);
  logic       act_q;
  logic [7:0] base_hi_q;
  logic [3:0] base_lo_q;
  logic [3:0] irq_num_q;
  logic       irq_wake_q;
  logic       type_q;
  logic       we;

  assign we = wr_i & bank_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      base_hi_q  <= '0;
      base_lo_q  <= '0;
      irq_num_q  <= '0;
      irq_wake_q <= 1'b0;
      type_q     <= 1'b1;
    end else if (we) begin
      unique case (idx_i)
        IDX_ACT:      act_q      <= wdata_i[0];
        IDX_BASE_HI:  base_hi_q  <= wdata_i;
        IDX_BASE_LO:  base_lo_q  <= wdata_i[7:4];
        IDX_IRQ_NUM: begin
          irq_num_q  <= wdata_i[3:0];
          irq_wake_q <= wdata_i[4];
        end
        IDX_IRQ_TYPE: type_q     <= wdata_i[1];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (bank_en_i) begin
      unique case (idx_i)
        IDX_ACT:      rdata_o = {7'b0, act_q};
        IDX_BASE_HI:  rdata_o = base_hi_q;
        IDX_BASE_LO:  rdata_o = {base_lo_q, 4'b0};
        IDX_IRQ_NUM:  rdata_o = {3'b0, irq_wake_q, irq_num_q};
        IDX_IRQ_TYPE: rdata_o = {6'b0, type_q, 1'b1};
        default:      rdata_o = '0;
      endcase
    end
  end

  assign cfg_o.active   = act_q;
  assign cfg_o.base     = {base_hi_q, base_lo_q, 4'b0};
  assign cfg_o.irq_num  = irq_num_q;
  assign cfg_o.irq_wake = irq_wake_q;
  assign cfg_o.irq_type = {type_q, 1'b1};

  // R7
  gated_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !bank_en_i) |=> $stable(cfg_o));

  // R8
  act_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_o.active) |-> $past(wr_i && bank_en_i && idx_i == IDX_ACT && wdata_i[0]));
endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfgspace_pkg::*;
#(
  parameter logic [15:0] BASE_STRAP1 = 16'h007E,
  parameter logic [15:0] BASE_STRAP0 = 16'h00EE,
  parameter logic [7:0]  LDN_MATCH   = 8'h1A,
  parameter logic [7:0]  DEV_ID      = 8'hFE,
  parameter logic [7:0]  REV_ID      = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_i,
  input  logic [15:0] io_addr_i,
  input  logic        io_rd_i,
  input  logic        io_wr_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic        io_hit_o,
  output logic        dev_active_o,
  output logic [15:0] dev_base_o,
  output logic [3:0]  irq_num_o,
  output logic        irq_wake_o,
  output logic [1:0]  irq_type_o
);
  logic      idx_wr, idx_rd, dat_wr, dat_rd;
  cfg_byte_t index_q, ldn_q, bank_rdata, dat_rdata;
  logic      bank_en;
  dev_cfg_t  dev_cfg;

  cfg_addr_decode #(
    .AW(CFG_AW), .BASE_STRAP1(BASE_STRAP1), .BASE_STRAP0(BASE_STRAP0)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i),
    .addr_i(io_addr_i), .rd_i(io_rd_i), .wr_i(io_wr_i),
    .idx_wr_o(idx_wr), .idx_rd_o(idx_rd), .dat_wr_o(dat_wr), .dat_rd_o(dat_rd),
    .hit_o(io_hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr) index_q <= io_wdata_i;
      if (dat_wr && index_q == IDX_LDN) ldn_q <= io_wdata_i;
    end
  end

  assign bank_en = (ldn_q == LDN_MATCH);

  cfg_dev_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .bank_en_i(bank_en),
    .idx_i(index_q), .wr_i(dat_wr), .wdata_i(io_wdata_i),
    .rdata_o(bank_rdata), .cfg_o(dev_cfg)
  );

  always_comb begin
    unique case (index_q)
      IDX_LDN:   dat_rdata = ldn_q;
      IDX_DEVID: dat_rdata = DEV_ID;
      IDX_REVID: dat_rdata = REV_ID;
      default:   dat_rdata = bank_rdata;
    endcase
  end

  assign io_rdata_o = idx_rd ? index_q : (dat_rd ? dat_rdata : '0);

  assign dev_active_o = dev_cfg.active;
  assign dev_base_o   = dev_cfg.base;
  assign irq_num_o    = dev_cfg.irq_num;
  assign irq_wake_o   = dev_cfg.irq_wake;
  assign irq_type_o   = dev_cfg.irq_type;

  // R4
  index_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> index_q == $past(io_wdata_i));

  // R3
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_hit_o |=> $stable(index_q) && $stable(ldn_q));
endmodule

// File: tb/sim_cfgspace_regfile.sv
module sim_cfgspace_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit, active, wake;
  logic [15:0] base;
  logic [3:0]  irqn;
  logic [1:0]  itype;

  int n_run = 0, n_fail = 0;
  logic [15:0] pb = 16'h007E;

  always #2 clk = ~clk;

  cfgspace_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
    .io_addr_i(addr), .io_rd_i(rd), .io_wr_i(wr), .io_wdata_i(wdata),
    .io_rdata_o(rdata), .io_hit_o(hit),
    .dev_active_o(active), .dev_base_o(base), .irq_num_o(irqn),
    .irq_wake_o(wake), .irq_type_o(itype)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); addr = a; rd = 1'b1;
    #1; d = rdata; h = hit;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_wr(pb, idx); io_wr(pb + 16'd1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    logic h;
    io_wr(pb, idx); io_rd(pb + 16'd1, d, h);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic h;
    chk("R1 active", {15'b0, active}, 16'h0);
    chk("R1 base", base, 16'h0);
    chk("R1 irqnum", {12'b0, irqn}, 16'h0);
    chk("R1 wake", {15'b0, wake}, 16'h0);
    chk("R1 type", {14'b0, itype}, 16'h3);
    io_rd(pb, d, h);
    chk("R1 index", {8'b0, d}, 16'h0);
    reg_rd(8'h07, d);
    chk("R1 ldn", {8'b0, d}, 16'h0);
    reg_wr(8'h07, 8'h1A);
    reg_rd(8'h71, d); chk("R1 type reg", {8'b0, d}, 16'h03);
    reg_rd(8'h30, d); chk("R1 act reg", {8'b0, d}, 16'h00);
    reg_rd(8'h60, d); chk("R1 base hi", {8'b0, d}, 16'h00);
    reg_rd(8'h70, d); chk("R1 irq reg", {8'b0, d}, 16'h00);
  endtask

  task automatic t_index_ldn();
    logic [7:0] d; logic h;
    io_wr(pb, 8'hA5);
    io_rd(pb, d, h);
    chk("R4 index rd", {8'b0, d}, 16'h00A5);
    chk("R4 hit", {15'b0, h}, 16'h1);
    reg_wr(8'h07, 8'h5C);
    reg_rd(8'h07, d); chk("R5 ldn rw", {8'b0, d}, 16'h005C);
    reg_wr(8'h07, 8'h1A);
    reg_rd(8'h07, d); chk("R5 ldn rw2", {8'b0, d}, 16'h001A);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    reg_rd(8'h20, d); chk("R6 devid", {8'b0, d}, 16'h00FE);
    reg_wr(8'h20, 8'h55);
    reg_rd(8'h20, d); chk("R6 devid ro", {8'b0, d}, 16'h00FE);
    reg_wr(8'h27, 8'hAA);
    reg_rd(8'h27, d); chk("R6 revid", {8'b0, d}, 16'h0001);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h30, 8'h01);
    chk("R7 gated act", {15'b0, active}, 16'h0);
    reg_rd(8'h30, d); chk("R7 gated rd", {8'b0, d}, 16'h0);
    reg_rd(8'h71, d); chk("R7 gated 71", {8'b0, d}, 16'h0);
    reg_wr(8'h07, 8'h1A);
    reg_wr(8'h30, 8'hFF);
    chk("R8 active", {15'b0, active}, 16'h1);
    reg_rd(8'h30, d); chk("R8 act rd", {8'b0, d}, 16'h01);
    reg_wr(8'h07, 8'h1B);
    reg_rd(8'h30, d); chk("R7 1B rd", {8'b0, d}, 16'h0);
    reg_wr(8'h30, 8'h00);
    chk("R7 retained", {15'b0, active}, 16'h1);
    reg_wr(8'h07, 8'h1A);
    reg_wr(8'h30, 8'h00);
    chk("R8 clear", {15'b0, active}, 16'h0);
  endtask

  task automatic t_base_irq();
    logic [7:0] d;
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'hFF);
    reg_rd(8'h61, d); chk("R9 lo rd", {8'b0, d}, 16'h00F0);
    reg_rd(8'h60, d); chk("R9 hi rd", {8'b0, d}, 16'h0012);
    chk("R9 base out", base, 16'h12F0);
    reg_wr(8'h70, 8'hFF);
    reg_rd(8'h70, d); chk("R10 irq rd", {8'b0, d}, 16'h001F);
    chk("R10 num", {12'b0, irqn}, 16'hF);
    chk("R10 wake", {15'b0, wake}, 16'h1);
    reg_wr(8'h70, 8'h06);
    chk("R10 num2", {12'b0, irqn}, 16'h6);
    chk("R10 wake2", {15'b0, wake}, 16'h0);
    reg_wr(8'h71, 8'h00);
    reg_rd(8'h71, d); chk("R11 type 0", {8'b0, d}, 16'h01);
    chk("R11 type out", {14'b0, itype}, 16'h1);
    reg_wr(8'h71, 8'hFF);
    reg_rd(8'h71, d); chk("R11 type ff", {8'b0, d}, 16'h03);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    reg_wr(8'h45, 8'hAA);
    reg_rd(8'h45, d); chk("R12 45", {8'b0, d}, 16'h0);
    reg_rd(8'h72, d); chk("R12 72", {8'b0, d}, 16'h0);
    reg_rd(8'h00, d); chk("R12 00", {8'b0, d}, 16'h0);
    reg_rd(8'h60, d); chk("R12 no side", {8'b0, d}, 16'h0012);
  endtask

  task automatic t_addr();
    logic [7:0] d; logic h;
    io_wr(pb, 8'h30);
    io_rd(16'h017F, d, h);
    chk("R3 miss hit", {15'b0, h}, 16'h0);
    chk("R3 miss data", {8'b0, d}, 16'h0);
    io_wr(16'h017F, 8'h01);
    io_wr(16'h007D, 8'h01);
    io_wr(16'h0080, 8'h01);
    chk("R3 no write", {15'b0, active}, 16'h0);
    io_rd(pb, d, h);
    chk("R3 index kept", {8'b0, d}, 16'h0030);
  endtask

  task automatic t_strap();
    logic [7:0] d; logic h;
    do_reset(1'b0);
    strap = 1'b1;
    @(negedge clk);
    io_rd(16'h007E, d, h);
    chk("R2 old pair", {15'b0, h}, 16'h0);
    pb = 16'h00EE;
    io_wr(pb, 8'h20);
    io_rd(16'h00EF, d, h);
    chk("R2 alt pair hit", {15'b0, h}, 16'h1);
    chk("R2 alt pair data", {8'b0, d}, 16'h00FE);
  endtask

  initial begin
    do_reset(1'b1);
    t_reset();
    t_index_ldn();
    t_ids();
    t_gate();
    t_base_irq();
    t_unimpl();
    t_addr();
    t_strap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule